// File: doc/BRIEF.md
# Burst-Capable Memory Slave on an AXI4 Port

This block is a small on-chip memory that answers an AXI4 memory-mapped master. A write arrives as one address transfer, a train of data beats, and one response; a read arrives as one address transfer and is answered with one data beat per requested beat. Storage is byte-addressed and held in per-byte-lane arrays. Write strobes choose which bytes of each beat land in memory.

For every beat the block works out the address itself from the start address, the beat size and the burst kind. A fixed burst revisits the same location on every beat, and an incrementing burst steps by the beat size. Unsupported burst kinds, oversized beats and write bursts whose last-beat flag sits in the wrong place are answered with an error status. The transaction ID captured with the address comes back on the matching response.

The write side and the read side are independent, and each holds at most one transaction at a time. A master uses it as a scratch memory or as a target for exercising interconnect and DMA logic.

Top module: `axi_burst_mem`

## Requirements
- R1: A transfer on any channel takes place only on a clock edge where its valid and ready are both high. While b_valid or r_valid is high and the master's ready is low, the valid stays high and the response payload (ID, status, data, last flag) stays unchanged.
- R2: A burst has len+1 beats (len from 0 to 15). A read returns exactly len+1 data beats, with r_last high on the final beat only.
- R3: In an incrementing burst (burst code 01), each beat's address is the previous beat's address plus 2^size bytes. Size codes 0, 1 and 2 mean 1, 2 and 4 bytes.
- R4: In a fixed burst (burst code 00), every beat uses the start address.
- R5: Bit i of w_strb enables storing byte lane i (w_data bits 8i+7 to 8i) at the beat's word. Lanes whose strobe is low keep their previous contents.
- R6: A write gets exactly one response, after its data beats. The status is 00 (OKAY) when w_last comes on beat len+1 and is absent before it. The status is 10 (SLVERR) when w_last comes early or late. For a late flag, beats past len+1 are accepted and discarded until w_last.
- R7: A burst with code 10 or 11, or with a size above 2, is answered with SLVERR: on the write response, or on every read beat. Such a write stores nothing.
- R8: The write data received is readable afterwards at the addresses the burst covered.
- R9: aw_ready is low from the write address transfer until the write response has been accepted. ar_ready is low from the read address transfer until the last read beat has been accepted.
- R10: b_id and r_id equal the ID given with the address of the same transaction.
- R11: While rst (synchronous, active high) is applied, b_valid and r_valid go low. After rst is released, both address readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write start byte address |
| aw_len | input | LEN_W | Write beats minus one |
| aw_size | input | 3 | Write bytes per beat, log2 |
| aw_burst | input | 2 | Write burst kind |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte lane enables |
| w_last | input | 1 | Master's final-beat flag |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write status |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read start byte address |
| ar_len | input | LEN_W | Read beats minus one |
| ar_size | input | 3 | Read bytes per beat, log2 |
| ar_burst | input | 2 | Read burst kind |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | ID_W | Read data ID |
| r_data | output | DATA_W | Read data |
| r_resp | output | 2 | Read beat status |
| r_last | output | 1 | Final read beat |

## Verification
aw_ready falls on the edge that takes the write address, and w_ready is high from that edge onward. b_valid appears on the edge after the final beat handshake. A read beat becomes valid two edges after the address or previous beat handshake, because the memory is read through a register. The bench drives and samples on falling edges and waits on the valid or ready level rather than counting fixed delays. It also checks the readies and the held payloads on each falling edge of a deliberate stall, so every result is observed in the cycle it is due and not before.

// File: rtl/axi_mem_pkg.sv
package axi_mem_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] KIND_FIXED  = 2'b00;
  localparam logic [1:0] KIND_INCR   = 2'b01;

  function automatic logic burst_bad(input logic [1:0] kind, input logic [2:0] size,
                                     input logic [2:0] size_max);
    return !(kind == KIND_FIXED || kind == KIND_INCR) || (size > size_max);
  endfunction
endpackage

// File: rtl/axi_mem_beat_addr.sv
module axi_mem_beat_addr #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        size,
  input  logic [1:0]        kind,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] step;
  always_comb begin
    step = ADDR_W'(1) << size;
    nxt  = (kind == axi_mem_pkg::KIND_INCR) ? cur + step : cur;
  end
endmodule

// File: rtl/axi_mem_store.sv
module axi_mem_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LANES-1:0]  wstrb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (we && wstrb[g]) lane_mem[widx] <= wdata[g*8 +: 8];
      if (re) lane_q <= lane_mem[ridx];
    end
    assign rdata[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/axi_mem_wr_ctl.sv
module axi_mem_wr_ctl #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 4,
  parameter int OFF_W  = 2,
  parameter logic [2:0] SIZE_MAX = 3'd2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    aw_valid,
  output logic                    aw_ready,
  input  logic [ID_W-1:0]         aw_id,
  input  logic [ADDR_W-1:0]       aw_addr,
  input  logic [LEN_W-1:0]        aw_len,
  input  logic [2:0]              aw_size,
  input  logic [1:0]              aw_burst,
  input  logic                    w_valid,
  output logic                    w_ready,
  input  logic                    w_last,
  output logic                    b_valid,
  input  logic                    b_ready,
  output logic [ID_W-1:0]         b_id,
  output logic [1:0]              b_resp,
  output logic                    st_we,
  output logic [ADDR_W-OFF_W-1:0] st_idx
);
  typedef enum logic [1:0] {WS_ADDR, WS_DATA, WS_RESP} wstate_t;
  wstate_t           state;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W:0]    cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        kind_q;
  logic              bad_q, err_q;
  logic              beat_fire, in_range, at_end;

  axi_mem_beat_addr #(.ADDR_W(ADDR_W)) i_step (
    .cur(addr_q), .size(size_q), .kind(kind_q), .nxt(addr_nxt));

  assign aw_ready  = (state == WS_ADDR);
  assign w_ready   = (state == WS_DATA);
  assign b_valid   = (state == WS_RESP);
  assign b_id      = id_q;
  assign b_resp    = err_q ? axi_mem_pkg::RESP_SLVERR : axi_mem_pkg::RESP_OKAY;
  assign beat_fire = w_valid && w_ready;
  assign in_range  = cnt_q <= {1'b0, len_q};
  assign at_end    = cnt_q == {1'b0, len_q};
  assign st_we     = beat_fire && in_range && !bad_q;
  assign st_idx    = addr_q[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WS_ADDR;
      err_q <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      case (state)
        WS_ADDR: if (aw_valid) begin
          id_q   <= aw_id;
          addr_q <= aw_addr;
          len_q  <= aw_len;
          size_q <= aw_size;
          kind_q <= aw_burst;
          cnt_q  <= '0;
          bad_q  <= axi_mem_pkg::burst_bad(aw_burst, aw_size, SIZE_MAX);
          err_q  <= axi_mem_pkg::burst_bad(aw_burst, aw_size, SIZE_MAX);
          state  <= WS_DATA;
        end
        WS_DATA: if (beat_fire) begin
          if (w_last) begin
            if (!at_end) err_q <= 1'b1;
            state <= WS_RESP;
          end else if (at_end || !in_range) begin
            err_q <= 1'b1;
          end
          if (in_range) cnt_q <= cnt_q + 1'b1;
          addr_q <= addr_nxt;
        end
        default: if (b_ready) state <= WS_ADDR;
      endcase
    end
  end
endmodule

// File: rtl/axi_mem_rd_ctl.sv
module axi_mem_rd_ctl #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 10,
  parameter int LEN_W  = 4,
  parameter int OFF_W  = 2,
  parameter logic [2:0] SIZE_MAX = 3'd2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ar_valid,
  output logic                    ar_ready,
  input  logic [ID_W-1:0]         ar_id,
  input  logic [ADDR_W-1:0]       ar_addr,
  input  logic [LEN_W-1:0]        ar_len,
  input  logic [2:0]              ar_size,
  input  logic [1:0]              ar_burst,
  output logic                    r_valid,
  input  logic                    r_ready,
  output logic [ID_W-1:0]         r_id,
  output logic [1:0]              r_resp,
  output logic                    r_last,
  output logic                    st_re,
  output logic [ADDR_W-OFF_W-1:0] st_idx
);
  typedef enum logic [1:0] {RS_ADDR, RS_FETCH, RS_SEND} rstate_t;
  rstate_t           state;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [2:0]        size_q;
  logic [1:0]        kind_q;
  logic              bad_q;

  axi_mem_beat_addr #(.ADDR_W(ADDR_W)) i_step (
    .cur(addr_q), .size(size_q), .kind(kind_q), .nxt(addr_nxt));

  assign ar_ready = (state == RS_ADDR);
  assign r_valid  = (state == RS_SEND);
  assign r_id     = id_q;
  assign r_resp   = bad_q ? axi_mem_pkg::RESP_SLVERR : axi_mem_pkg::RESP_OKAY;
  assign r_last   = (cnt_q == len_q);
  assign st_re    = (state == RS_FETCH);
  assign st_idx   = addr_q[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RS_ADDR;
      bad_q <= 1'b0;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      case (state)
        RS_ADDR: if (ar_valid) begin
          id_q   <= ar_id;
          addr_q <= ar_addr;
          len_q  <= ar_len;
          size_q <= ar_size;
          kind_q <= ar_burst;
          cnt_q  <= '0;
          bad_q  <= axi_mem_pkg::burst_bad(ar_burst, ar_size, SIZE_MAX);
          state  <= RS_FETCH;
        end
        RS_FETCH: state <= RS_SEND;
        default: if (r_ready) begin
          if (cnt_q == len_q) begin
            state <= RS_ADDR;
          end else begin
            cnt_q  <= cnt_q + 1'b1;
            addr_q <= addr_nxt;
            state  <= RS_FETCH;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int OFF_W  = $clog2(STRB_W),
  localparam int WORDS  = 2 ** (ADDR_W - OFF_W),
  localparam logic [2:0] SIZE_MAX = 3'(OFF_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic [STRB_W-1:0] w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);
  logic                    st_we, st_re;
  logic [ADDR_W-OFF_W-1:0] st_widx, st_ridx;

  axi_mem_wr_ctl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W),
                   .SIZE_MAX(SIZE_MAX)) i_wr (
    .clk, .rst, .aw_valid, .aw_ready, .aw_id, .aw_addr, .aw_len, .aw_size, .aw_burst,
    .w_valid, .w_ready, .w_last, .b_valid, .b_ready, .b_id, .b_resp,
    .st_we(st_we), .st_idx(st_widx));

  axi_mem_rd_ctl #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W),
                   .SIZE_MAX(SIZE_MAX)) i_rd (
    .clk, .rst, .ar_valid, .ar_ready, .ar_id, .ar_addr, .ar_len, .ar_size, .ar_burst,
    .r_valid, .r_ready, .r_id, .r_resp, .r_last,
    .st_re(st_re), .st_idx(st_ridx));

  axi_mem_store #(.DATA_W(DATA_W), .WORDS(WORDS)) i_store (
    .clk, .we(st_we), .widx(st_widx), .wstrb(w_strb), .wdata(w_data),
    .re(st_re), .ridx(st_ridx), .rdata(r_data));
endmodule

// File: rtl/axi_burst_mem_chk.sv
module axi_burst_mem_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic              w_ready,
  input logic              b_valid,
  input logic              b_ready,
  input logic [ID_W-1:0]   b_id,
  input logic [1:0]        b_resp,
  input logic              ar_ready,
  input logic              r_valid,
  input logic              r_ready,
  input logic [ID_W-1:0]   r_id,
  input logic [DATA_W-1:0] r_data,
  input logic [1:0]        r_resp,
  input logic              r_last
);
  assert_b_hold_R1: assert property (@(posedge clk) disable iff (rst)
    b_valid && !b_ready |=> b_valid && $stable(b_resp) && $stable(b_id));
  assert_r_hold_R1: assert property (@(posedge clk) disable iff (rst)
    r_valid && !r_ready |=> r_valid && $stable(r_data) && $stable(r_last)
                            && $stable(r_resp) && $stable(r_id));
  assert_last_ends_R2: assert property (@(posedge clk) disable iff (rst)
    r_valid && r_ready && r_last |=> !r_valid);
  assert_resp_code_R6: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> (b_resp == 2'b00 || b_resp == 2'b10));
  assert_data_before_resp_R6: assert property (@(posedge clk) disable iff (rst)
    w_ready |-> !b_valid);
  assert_aw_single_R9: assert property (@(posedge clk) disable iff (rst)
    aw_valid && aw_ready |=> !aw_ready);
  assert_b_blocks_aw_R9: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> !aw_ready);
  assert_r_blocks_ar_R9: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> !ar_ready);
endmodule

bind axi_burst_mem axi_burst_mem_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(aw_ready), .w_ready(w_ready),
  .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
  .ar_ready(ar_ready), .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
  .r_data(r_data), .r_resp(r_resp), .r_last(r_last));

// File: tb/test_axi_burst_mem.sv
module test_axi_burst_mem;
  logic        clk = 0, rst = 1;
  logic        aw_valid = 0, aw_ready;
  logic [3:0]  aw_id = 0;
  logic [9:0]  aw_addr = 0;
  logic [3:0]  aw_len = 0;
  logic [2:0]  aw_size = 0;
  logic [1:0]  aw_burst = 0;
  logic        w_valid = 0, w_ready, w_last = 0;
  logic [31:0] w_data = 0;
  logic [3:0]  w_strb = 0;
  logic        b_valid, b_ready = 0;
  logic [3:0]  b_id;
  logic [1:0]  b_resp;
  logic        ar_valid = 0, ar_ready;
  logic [3:0]  ar_id = 0;
  logic [9:0]  ar_addr = 0;
  logic [3:0]  ar_len = 0;
  logic [2:0]  ar_size = 0;
  logic [1:0]  ar_burst = 0;
  logic        r_valid, r_ready = 0, r_last;
  logic [3:0]  r_id;
  logic [31:0] r_data;
  logic [1:0]  r_resp;

  int checks = 0, fails = 0;
  logic [7:0]  bm [0:1023];
  logic [31:0] wd [0:31];
  logic [3:0]  ws [0:31];
  logic [31:0] rd [0:31];
  logic [1:0]  rr [0:31];
  logic        rl [0:31];
  logic [3:0]  ri [0:31];

  always #5 clk = ~clk;

  axi_burst_mem i_axi_burst_mem (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [9:0] a);
    return {bm[{a[9:2], 2'd3}], bm[{a[9:2], 2'd2}], bm[{a[9:2], 2'd1}], bm[{a[9:2], 2'd0}]};
  endfunction

  task automatic do_write(input logic [3:0] id, input logic [9:0] addr, input logic [3:0] len,
                          input logic [2:0] size, input logic [1:0] kind, input int nbeats,
                          input int stall, output logic [1:0] resp, output logic [3:0] bid);
    logic [9:0] a;
    logic ok;
    logic [1:0] r0;
    @(negedge clk);
    aw_valid = 1; aw_id = id; aw_addr = addr; aw_len = len; aw_size = size; aw_burst = kind;
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 0;
    chk("R9 aw_ready low during data", 32'(aw_ready), 0);
    ok = (kind == 2'b00 || kind == 2'b01) && size <= 3'd2;
    a = addr;
    for (int i = 0; i < nbeats; i++) begin
      w_valid = 1; w_data = wd[i]; w_strb = ws[i]; w_last = (i == nbeats - 1);
      while (!w_ready) @(negedge clk);
      if (ok && i <= int'(len))
        for (int j = 0; j < 4; j++)
          if (ws[i][j]) bm[{a[9:2], 2'(j)}] = wd[i][8*j +: 8];
      if (kind == 2'b01) a = a + (10'd1 << size);
      @(negedge clk);
    end
    w_valid = 0; w_last = 0;
    while (!b_valid) @(negedge clk);
    r0 = b_resp;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R1 b_valid held", 32'(b_valid), 1);
      chk("R1 b_resp held", 32'(b_resp), 32'(r0));
      chk("R9 aw_ready low with response pending", 32'(aw_ready), 0);
    end
    resp = b_resp; bid = b_id;
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
    chk("R9 aw_ready back after response", 32'(aw_ready), 1);
    chk("R6 single response", 32'(b_valid), 0);
  endtask

  task automatic do_read(input logic [3:0] id, input logic [9:0] addr, input logic [3:0] len,
                         input logic [2:0] size, input logic [1:0] kind, input int stall);
    logic [31:0] d0;
    @(negedge clk);
    ar_valid = 1; ar_id = id; ar_addr = addr; ar_len = len; ar_size = size; ar_burst = kind;
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = 0;
    for (int i = 0; i <= int'(len); i++) begin
      while (!r_valid) @(negedge clk);
      if (i == 0) begin
        d0 = r_data;
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          chk("R1 r_valid held", 32'(r_valid), 1);
          chk("R1 r_data held", r_data, d0);
          chk("R9 ar_ready low during burst", 32'(ar_ready), 0);
        end
      end
      rd[i] = r_data; rr[i] = r_resp; rl[i] = r_last; ri[i] = r_id;
      r_ready = 1;
      @(negedge clk);
      r_ready = 0;
    end
    repeat (3) begin
      chk("R2 no extra read beat", 32'(r_valid), 0);
      @(negedge clk);
    end
    chk("R9 ar_ready back after burst", 32'(ar_ready), 1);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R11 b_valid in reset", 32'(b_valid), 0);
    chk("R11 r_valid in reset", 32'(r_valid), 0);
    rst = 0;
    @(negedge clk);
    chk("R11 aw_ready after reset", 32'(aw_ready), 1);
    chk("R11 ar_ready after reset", 32'(ar_ready), 1);
  endtask

  task automatic t_incr();
    logic [1:0] resp; logic [3:0] bid;
    for (int i = 0; i < 4; i++) begin wd[i] = 32'h10 + 32'(i); ws[i] = 4'hF; end
    do_write(4'd3, 10'h000, 4'd3, 3'd2, 2'b01, 4, 0, resp, bid);
    chk("R6 incr write OKAY", 32'(resp), 32'h0);
    chk("R10 write ID echo", 32'(bid), 32'h3);
    do_read(4'd9, 10'h000, 4'd3, 3'd2, 2'b01, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R8 R3 incr read data", rd[i], 32'h10 + 32'(i));
      chk("R2 r_last only on final", 32'(rl[i]), 32'(i == 3));
      chk("R7 read status OKAY", 32'(rr[i]), 0);
      chk("R10 read ID echo", 32'(ri[i]), 32'h9);
    end
  endtask

  task automatic t_fixed();
    logic [1:0] resp; logic [3:0] bid;
    wd[0] = 32'hAAAA0001; wd[1] = 32'hBBBB0002; wd[2] = 32'hCCCC0003;
    for (int i = 0; i < 3; i++) ws[i] = 4'hF;
    wd[3] = 32'h0; ws[3] = 4'hF;
    do_write(4'd1, 10'h044, 4'd0, 3'd2, 2'b01, 1, 0, resp, bid);
    do_write(4'd2, 10'h040, 4'd2, 3'd2, 2'b00, 3, 0, resp, bid);
    chk("R6 fixed write OKAY", 32'(resp), 0);
    do_read(4'd4, 10'h040, 4'd2, 3'd2, 2'b00, 0);
    for (int i = 0; i < 3; i++) chk("R4 fixed read same word", rd[i], 32'hCCCC0003);
    do_read(4'd4, 10'h044, 4'd0, 3'd2, 2'b01, 0);
    chk("R4 neighbour word untouched", rd[0], 32'hAAAA0001);
  endtask

  task automatic t_strobe();
    logic [1:0] resp; logic [3:0] bid;
    wd[0] = 32'hFFFFFFFF; ws[0] = 4'hF;
    do_write(4'd0, 10'h080, 4'd0, 3'd2, 2'b01, 1, 0, resp, bid);
    wd[0] = 32'h11223344; ws[0] = 4'b0101;
    do_write(4'd0, 10'h080, 4'd0, 3'd2, 2'b01, 1, 0, resp, bid);
    do_read(4'd0, 10'h080, 4'd0, 3'd2, 2'b01, 0);
    chk("R5 strobe lanes", rd[0], 32'hFF22FF44);
  endtask

  task automatic t_halfword();
    logic [1:0] resp; logic [3:0] bid;
    for (int i = 0; i < 4; i++) begin
      wd[i] = 32'h0101_0101 * (32'(i) + 32'h5);
      ws[i] = (i % 2 == 0) ? 4'b0011 : 4'b1100;
    end
    do_write(4'd5, 10'h100, 4'd3, 3'd1, 2'b01, 4, 0, resp, bid);
    chk("R3 halfword write OKAY", 32'(resp), 0);
    do_read(4'd5, 10'h100, 4'd1, 3'd2, 2'b01, 0);
    chk("R3 halfword beats word 0", rd[0], exp_word(10'h100));
    chk("R3 halfword beats word 1", rd[1], exp_word(10'h104));
  endtask

  task automatic t_last_mismatch();
    logic [1:0] resp; logic [3:0] bid;
    for (int i = 0; i < 4; i++) begin wd[i] = 32'h7700 + 32'(i); ws[i] = 4'hF; end
    do_write(4'd6, 10'h180, 4'd3, 3'd2, 2'b01, 2, 0, resp, bid);
    chk("R6 early last SLVERR", 32'(resp), 32'h2);
    chk("R10 ID on error response", 32'(bid), 32'h6);
    do_write(4'd7, 10'h1C0, 4'd1, 3'd2, 2'b01, 4, 0, resp, bid);
    chk("R6 late last SLVERR", 32'(resp), 32'h2);
    do_read(4'd7, 10'h1C0, 4'd3, 3'd2, 2'b01, 0);
    chk("R6 late burst beat 1 stored", rd[1], 32'h7701);
    chk("R6 surplus beat discarded", rd[2], exp_word(10'h1C8));
    do_write(4'd8, 10'h1C0, 4'd0, 3'd2, 2'b01, 1, 0, resp, bid);
    chk("R6 recovery OKAY", 32'(resp), 0);
  endtask

  task automatic t_bad_kind();
    logic [1:0] resp; logic [3:0] bid;
    wd[0] = 32'h55555555; ws[0] = 4'hF;
    do_write(4'd1, 10'h200, 4'd0, 3'd2, 2'b01, 1, 0, resp, bid);
    wd[0] = 32'hAAAAAAAA; wd[1] = 32'hAAAAAAAA; ws[1] = 4'hF;
    do_write(4'd2, 10'h200, 4'd1, 3'd2, 2'b10, 2, 0, resp, bid);
    chk("R7 wrap write SLVERR", 32'(resp), 32'h2);
    do_write(4'd2, 10'h200, 4'd0, 3'd3, 2'b01, 1, 0, resp, bid);
    chk("R7 oversize write SLVERR", 32'(resp), 32'h2);
    do_read(4'd3, 10'h200, 4'd0, 3'd2, 2'b01, 0);
    chk("R7 rejected writes store nothing", rd[0], 32'h55555555);
    do_read(4'd3, 10'h200, 4'd1, 3'd2, 2'b10, 0);
    chk("R7 wrap read beat 0 SLVERR", 32'(rr[0]), 32'h2);
    chk("R7 wrap read beat 1 SLVERR", 32'(rr[1]), 32'h2);
    chk("R2 wrap read last on beat 1", 32'(rl[1]), 1);
  endtask

  task automatic t_stalls();
    logic [1:0] resp; logic [3:0] bid;
    wd[0] = 32'hC0FFEE00; wd[1] = 32'hC0FFEE01; ws[0] = 4'hF; ws[1] = 4'hF;
    do_write(4'hA, 10'h300, 4'd1, 3'd2, 2'b01, 2, 4, resp, bid);
    chk("R10 ID after stalled response", 32'(bid), 32'hA);
    do_read(4'hB, 10'h300, 4'd1, 3'd2, 2'b01, 4);
    chk("R1 stalled read beat 0", rd[0], 32'hC0FFEE00);
    chk("R1 stalled read beat 1", rd[1], 32'hC0FFEE01);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_incr();
        t_fixed();
        t_strobe();
        t_halfword();
        t_last_mismatch();
        t_bad_kind();
        t_stalls();
      end
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule